// File: doc/BRIEF.md
# RMII receive dibit formatter

This block sits between a receive data path that delivers decoded 4-bit nibbles with a separate carrier indication and a MAC that expects reduced-pin receive signalling: a 2-bit data bus and a single combined carrier/data-valid line, all timed by one 50 MHz reference clock. Each nibble is split into two dibits, low half first. At 100 Mbps a new dibit goes out on every clock. At 10 Mbps each dibit is held for ten clocks.

Nibbles that arrive while carrier is present are queued in a small FIFO. When carrier drops with nibbles still queued, the combined line goes low on every first-dibit slot and high on every second-dibit slot until the queue drains. The MAC can therefore tell the end of carrier apart from the end of data. A false-carrier indication overrides the data path and presents an error code with the error flag set.

Top module: `rmii_rx_fmt`

## Requirements
- R1: While rst_ni is low, rxd_o is 00, crs_dv_o is 0 and rx_er_o is 0.
- R2: Outputs change only at slot edges. At 100 Mbps (rate_10m_i=0) every clock edge is a slot edge. At 10 Mbps (rate_10m_i=1) every 10th edge counted from reset release is a slot edge. The first slot after reset is a first-dibit slot, and slots then alternate between first and second dibit.
- R3: A nibble n is presented as n[1:0] in a first-dibit slot, followed by n[3:2] in the next slot. Nibbles go out in arrival order.
- R4: A nibble is accepted only on a clock where nib_valid_i=1, crs_i=1 and false_carrier_i=0, and only if the 4-entry FIFO is not full. Any other offered nibble is discarded.
- R5: If no nibble is being presented, rxd_o is 00. This includes the time between crs_dv_o rising and the first data.
- R6: crs_dv_o falls only in a first-dibit slot. If carrier is low at a slot edge while nibbles remain, crs_dv_o is 0 in first-dibit slots and 1 in second-dibit slots (25 MHz / 2.5 MHz toggling). Once the FIFO is empty, crs_dv_o is 0 from the next first-dibit slot on, and rxd_o stays 00.
- R7: At a slot edge where both crs_i and false_carrier_i are 1, the outputs are rxd_o=10, rx_er_o=1 and crs_dv_o=1. In all other slots rx_er_o is 0.
- R8: At any slot edge where crs_i is 1, crs_dv_o becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rate_10m_i | input | 1 | 1 selects 10 Mbps slot timing, 0 selects 100 Mbps |
| crs_i | input | 1 | Carrier present on the line |
| false_carrier_i | input | 1 | Current carrier event is a false carrier |
| nib_valid_i | input | 1 | Strobe: nib_i holds a decoded nibble |
| nib_i | input | 4 | Decoded receive nibble |
| rxd_o | output | 2 | Receive dibit to the MAC |
| crs_dv_o | output | 1 | Combined carrier sense / data valid |
| rx_er_o | output | 1 | Receive error (false carrier) |

## Verification
Every output is registered at a slot edge, so a result is due at the first slot edge after the inputs that cause it. The design samples carrier, false carrier and FIFO state on that same edge. The bench keeps its own edge count from reset release to find slot edges: every edge at 100 Mbps, every tenth edge at 10 Mbps. It also records crs_i and false_carrier_i as seen at each edge and compares the outputs half a clock after each slot edge. Between slot edges it checks that nothing moved. The driver queues expected dibits only for the nibbles that R4 says are accepted. The monitor aligns the queue to the first non-zero dibit of a frame and then pops one entry per slot.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  localparam logic [1:0] DIBIT_IDLE  = 2'b00;
  localparam logic [1:0] DIBIT_FALSE = 2'b10;

  typedef struct packed {
    logic       dv;
    logic       er;
    logic [1:0] d;
  } rx_slot_t;
endpackage

// File: rtl/rmii_rx_tick.sv
module rmii_rx_tick #(
  parameter int SLOW_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o,
  output logic cur_second_o
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  assign tick_o       = !slow_i || (cnt_q == LAST);
  assign cur_second_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // reset to "second" so the first slot presented is a first dibit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= 1'b1;
    end else if (tick_o) begin
      ph_q <= ~ph_q;
    end
  end
endmodule

// File: rtl/rmii_rx_fifo.sv
module rmii_rx_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, do_push, do_pop;

  assign full    = (cnt_q == CFULL);
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PLAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PLAST) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rmii_rx_slot.sv
module rmii_rx_slot
  import rmii_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     cur_second_i,
  input  logic     crs_i,
  input  logic     fc_i,
  input  logic     empty_i,
  input  logic [3:0] head_i,
  output logic     pop_o,
  output rx_slot_t out_o
);
  rx_slot_t   out_q, out_d;
  logic       pend_q, pend_d;
  logic [1:0] hi_q, hi_d;
  logic       next_first, fc_act;

  assign next_first = cur_second_i;
  assign fc_act     = crs_i && fc_i;
  assign out_o      = out_q;

  always_comb begin
    out_d  = out_q;
    pend_d = 1'b0;
    hi_d   = hi_q;
    pop_o  = 1'b0;
    if (fc_act) begin
      out_d = '{dv: 1'b1, er: 1'b1, d: DIBIT_FALSE};
    end else if (next_first) begin
      if (!empty_i) begin
        pop_o  = tick_i;
        pend_d = 1'b1;
        hi_d   = head_i[3:2];
        out_d  = '{dv: crs_i, er: 1'b0, d: head_i[1:0]};
      end else begin
        out_d  = '{dv: crs_i, er: 1'b0, d: DIBIT_IDLE};
      end
    end else if (pend_q) begin
      out_d = '{dv: 1'b1, er: 1'b0, d: hi_q};
    end else begin
      // no deassertion on a second-dibit slot
      out_d = '{dv: out_q.dv | crs_i, er: 1'b0, d: DIBIT_IDLE};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '{dv: 1'b0, er: 1'b0, d: DIBIT_IDLE};
      pend_q <= 1'b0;
      hi_q   <= DIBIT_IDLE;
    end else if (tick_i) begin
      out_q  <= out_d;
      pend_q <= pend_d;
      hi_q   <= hi_d;
    end
  end
endmodule

// File: rtl/rmii_rx_fmt.sv
module rmii_rx_fmt
  import rmii_rx_pkg::*;
#(
  parameter int SLOW_DIV   = 10,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rate_10m_i,
  input  logic       crs_i,
  input  logic       false_carrier_i,
  input  logic       nib_valid_i,
  input  logic [3:0] nib_i,
  output logic [1:0] rxd_o,
  output logic       crs_dv_o,
  output logic       rx_er_o
);
  logic       tick, cur_second, fifo_empty, fifo_pop, fifo_push;
  logic [3:0] fifo_head;
  rx_slot_t   slot;

  assign fifo_push = nib_valid_i && crs_i && !false_carrier_i;

  rmii_rx_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slow_i      (rate_10m_i),
    .tick_o      (tick),
    .cur_second_o(cur_second)
  );

  rmii_rx_fifo #(.W(4), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (fifo_push),
    .data_i (nib_i),
    .pop_i  (fifo_pop),
    .head_o (fifo_head),
    .empty_o(fifo_empty)
  );

  rmii_rx_slot u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .cur_second_i(cur_second),
    .crs_i       (crs_i),
    .fc_i        (false_carrier_i),
    .empty_i     (fifo_empty),
    .head_i      (fifo_head),
    .pop_o       (fifo_pop),
    .out_o       (slot)
  );

  assign rxd_o    = slot.d;
  assign crs_dv_o = slot.dv;
  assign rx_er_o  = slot.er;
endmodule

// File: rtl/rmii_rx_fmt_chk.sv
module rmii_rx_fmt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       cur_second_i,
  input logic       crs_i,
  input logic       fifo_empty_i,
  input logic [1:0] rxd_o,
  input logic       crs_dv_o,
  input logic       rx_er_o
);
  a_r2_hold_between_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable({crs_dv_o, rxd_o, rx_er_o}));

  a_r6_fall_on_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(crs_dv_o) |-> !cur_second_i);

  a_r7_error_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_er_o |-> (rxd_o == 2'b10 && crs_dv_o));

  a_r8_dv_on_carrier: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && crs_i) |=> crs_dv_o);

  a_r4_no_push_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!crs_i && fifo_empty_i) |=> fifo_empty_i);
endmodule

bind rmii_rx_fmt rmii_rx_fmt_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick),
  .cur_second_i(cur_second),
  .crs_i       (crs_i),
  .fifo_empty_i(fifo_empty),
  .rxd_o       (rxd_o),
  .crs_dv_o    (crs_dv_o),
  .rx_er_o     (rx_er_o)
);

// File: tb/rmii_rx_fmt_bench.sv
`timescale 1ns/1ps
module rmii_rx_fmt_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rate_10m_i = 1'b0;
  logic       crs_i = 1'b0;
  logic       false_carrier_i = 1'b0;
  logic       nib_valid_i = 1'b0;
  logic [3:0] nib_i = 4'h0;
  logic [1:0] rxd_o;
  logic       crs_dv_o, rx_er_o;

  always #10 clk_i = ~clk_i;

  rmii_rx_fmt u_rmii_rx_fmt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rate_10m_i     (rate_10m_i),
    .crs_i          (crs_i),
    .false_carrier_i(false_carrier_i),
    .nib_valid_i    (nib_valid_i),
    .nib_i          (nib_i),
    .rxd_o          (rxd_o),
    .crs_dv_o       (crs_dv_o),
    .rx_er_o        (rx_er_o)
  );

  int         n_cmp = 0;
  int         n_bad = 0;
  logic [1:0] q[$];
  int         pcnt;
  logic       crs_e = 1'b0, fc_e = 1'b0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pcnt <= 0;
    else         pcnt <= pcnt + 1;
  end

  always @(posedge clk_i) begin
    crs_e <= crs_i;
    fc_e  <= false_carrier_i;
  end

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor / scoreboard
  logic       started = 1'b0;
  logic       exp_dv = 1'b0;
  logic [1:0] last_rxd = 2'b00;
  logic       last_dv = 1'b0, last_er = 1'b0;

  always @(negedge clk_i) begin
    int div;
    int sn;
    logic first;
    logic [1:0] e;
    if (!rst_ni) begin
      started  = 1'b0;
      exp_dv   = 1'b0;
      last_rxd = 2'b00;
      last_dv  = 1'b0;
      last_er  = 1'b0;
    end else begin
      div = rate_10m_i ? 10 : 1;
      if (pcnt != 0 && (pcnt % div) == 0) begin
        sn    = pcnt / div;
        first = (sn % 2) == 1;
        if (crs_e && fc_e) begin
          check("R7 false-carrier rxd", rxd_o, 2);
          check("R7 false-carrier rx_er", rx_er_o, 1);
          check("R7 false-carrier crs_dv", crs_dv_o, 1);
          exp_dv = 1'b1;
        end else begin
          if (!started && first && q.size() > 0 && rxd_o != 2'b00) started = 1'b1;
          exp_dv = crs_e ? 1'b1 : (first ? 1'b0 : (exp_dv | started));
          if (started) begin
            e = q.pop_front();
            check("R3 data dibit", rxd_o, e);
            if (!first && q.size() == 0) started = 1'b0;
          end else begin
            check("R5 idle rxd", rxd_o, 0);
          end
          check("R6 R8 crs_dv", crs_dv_o, exp_dv);
          check("R7 rx_er idle", rx_er_o, 0);
        end
        last_rxd = rxd_o;
        last_dv  = crs_dv_o;
        last_er  = rx_er_o;
      end else begin
        if (rxd_o != last_rxd || crs_dv_o != last_dv || rx_er_o != last_er)
          check("R2 hold between slots", {rxd_o, crs_dv_o, rx_er_o},
                {last_rxd, last_dv, last_er});
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk_i);
    #5;
  endtask

  task automatic push(logic [3:0] v, bit ok);
    nib_valid_i = 1'b1;
    nib_i       = v;
    if (ok) begin
      q.push_back(v[1:0]);
      q.push_back(v[3:2]);
    end
    cyc(1);
    nib_valid_i = 1'b0;
  endtask

  task automatic check_reset_outputs();
    check("R1 reset rxd", rxd_o, 0);
    check("R1 reset crs_dv", crs_dv_o, 0);
    check("R1 reset rx_er", rx_er_o, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] tail [5];
    tail[0] = 4'h0; tail[1] = 4'hF; tail[2] = 4'h6; tail[3] = 4'hA; tail[4] = 4'hC;
    cyc(3);
    check_reset_outputs();
    rst_ni = 1'b1;
    cyc(5);

    // R3 R5 R6 R8: 100 Mbps frame, carrier dropped with nibbles still queued
    crs_i = 1'b1;
    cyc(3);
    push(4'h5, 1'b1);
    push(4'hD, 1'b1);
    push(4'h3, 1'b1);
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      push(tail[i], 1'b1);
    end
    crs_i = 1'b0;
    cyc(30);
    check("R3 all dibits delivered (100M)", q.size(), 0);

    // R7 R4: false carrier, offered nibbles must be discarded
    crs_i = 1'b1;
    false_carrier_i = 1'b1;
    cyc(2);
    push(4'h7, 1'b0);
    push(4'h1, 1'b0);
    cyc(3);
    false_carrier_i = 1'b0;
    cyc(10);
    crs_i = 1'b0;
    cyc(10);

    // R2 R4 R6: 10 Mbps, FIFO overflow then drain toggling
    rst_ni = 1'b0;
    rate_10m_i = 1'b1;
    cyc(3);
    check_reset_outputs();
    rst_ni = 1'b1;
    do cyc(1); while (pcnt == 0 || (pcnt % 10) != 0);
    crs_i = 1'b1;
    push(4'h9, 1'b1);
    push(4'h2, 1'b1);
    push(4'hE, 1'b1);
    push(4'h7, 1'b1);
    push(4'hB, 1'b0);
    push(4'h4, 1'b0);
    cyc(25);
    crs_i = 1'b0;
    cyc(120);
    check("R4 R3 all dibits delivered (10M)", q.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule